// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point unit and keeps the sticky exception flags of the floating-point control/status register. Each completed operation reports a vector of fine-grained causes: the different kinds of invalid operation, overflow, underflow, divide-by-zero and inexact. The block folds these causes into a small set of flag bits and ORs them into the register. It does this only when the register's enable bit is set.

After each accepted operation the block checks the eight hardware flags. If any of them is set, it raises a one-cycle floating-point exception request and tags it with the program counter of the reporting operation. Software reads the register on a plain read port and replaces it whole through a write strobe. A write is the only way to clear flags, and it takes precedence over an operation report in the same cycle.

Top module: `fpx_flag_accum`

## Requirements
- R1: After reset the register reads 12'h000, the request output is low and the tagged PC is zero.
- R2: An operation report is ignored while the enable bit (bit 0) is clear. The register is unchanged and no request is raised.
- R3: Any invalid cause sets the invalid flag (bit 9). The invalid causes are cause bits 0 to 8: signalling NaN (0), quiet NaN (1), inf minus inf (2), inf divided by inf (3), zero divided by zero (4), inf times zero (5), bad conversion (6), bad compare (7) and bad square root (8).
- R4: A signalling-NaN cause (bit 0) also sets the SNaN flag (bit 5). A quiet-NaN cause (bit 1) also sets the QNaN flag (bit 6).
- R5: Each remaining cause sets its own flag: overflow (cause 9) sets bit 3, underflow (cause 10) sets bit 4, divide-by-zero (cause 11) sets bit 11 and inexact (cause 12) sets bit 8.
- R6: The inf minus inf and inf divided by inf causes (bits 2 and 3) also set the infinity flag (bit 10).
- R7: Flags are sticky. An operation report only ORs new flags into the register and never clears one.
- R8: One cycle after an accepted report, the request output is high for one cycle if the updated register has any of bits 3, 4, 5, 6, 8, 9, 10 or 11 set. This holds even when the report itself added none. The zero flag (bit 7) does not count. The tagged PC then shows the report's PC, and it holds that value until the next request.
- R9: A software write replaces all 12 register bits on the next cycle. A report in the same cycle is dropped and raises no request.
- R10: An operation report never changes the enable bit or the rounding-mode bits (2:1), and it never sets the zero flag (bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| op_valid_i | input | 1 | An operation report is present this cycle |
| op_cause_i | input | 13 | Per-operation cause vector (bit encoding in R3 to R6) |
| op_pc_i | input | PC_W | Program counter of the reporting operation |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 12 | Software write data |
| sw_rdata_o | output | 12 | Current control/status register value |
| fpe_req_o | output | 1 | One-cycle floating-point exception request |
| fpe_pc_o | output | PC_W | PC tagged to the last request |

## Verification
Two situations are hard to reach from the ports. The first is a request raised by an operation that reports no cause at all: flags left set by earlier operations must keep triggering. The second is a software write colliding with a report in the same cycle. Directed steps build both cases deliberately. One sequence sets flags and then sends an empty report. Another sets only the zero flag, which must not trigger a request. A third drives the write strobe and a report together. Random stimulus then mixes sparse cause vectors, an enable bit that is usually set, and occasional writes, so that sticky flags build up and are cleared again many times.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int CAUSE_W = 13;
    localparam int CSR_W   = 12;

    // cause vector positions
    localparam int C_SNAN  = 0;
    localparam int C_QNAN  = 1;
    localparam int C_ISI   = 2;
    localparam int C_IDI   = 3;
    localparam int C_SQRT  = 8;
    localparam int C_OVF   = 9;
    localparam int C_UNF   = 10;
    localparam int C_DIV0  = 11;
    localparam int C_INEX  = 12;

    // register bit positions
    localparam int B_EN    = 0;
    localparam int B_OVF   = 3;
    localparam int B_UNF   = 4;
    localparam int B_SNF   = 5;
    localparam int B_QNF   = 6;
    localparam int B_ZF    = 7;
    localparam int B_IXF   = 8;
    localparam int B_IVF   = 9;
    localparam int B_INF   = 10;
    localparam int B_DZF   = 11;

    // flags that trigger a request (zero flag excluded)
    localparam logic [CSR_W-1:0] TRIG_MASK = 12'hF78;
    // bits an operation report may never touch
    localparam logic [CSR_W-1:0] KEEP_MASK = 12'h087;
endpackage

// File: rtl/fpx_cause_fold.sv
module fpx_cause_fold
    import fpx_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [CSR_W-1:0]   flags_o
);
    always_comb begin
        flags_o        = '0;
        flags_o[B_IVF] = |cause_i[C_SQRT:C_SNAN];
        flags_o[B_SNF] = cause_i[C_SNAN];
        flags_o[B_QNF] = cause_i[C_QNAN];
        flags_o[B_INF] = cause_i[C_ISI] | cause_i[C_IDI];
        flags_o[B_OVF] = cause_i[C_OVF];
        flags_o[B_UNF] = cause_i[C_UNF];
        flags_o[B_DZF] = cause_i[C_DIV0];
        flags_o[B_IXF] = cause_i[C_INEX];
    end
endmodule

// File: rtl/fpx_event_check.sv
module fpx_event_check #(
    parameter int                 W    = 12,
    parameter logic [W-1:0]       MASK = '1
) (
    input  logic [W-1:0] value_i,
    output logic         hit_o
);
    logic [W-1:0] masked;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign masked[i] = value_i[i] & MASK[i];
    end

    assign hit_o = |masked;
endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
    import fpx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                op_valid_i,
    input  logic [CAUSE_W-1:0]  op_cause_i,
    input  logic [PC_W-1:0]     op_pc_i,
    input  logic                sw_we_i,
    input  logic [CSR_W-1:0]    sw_wdata_i,
    output logic [CSR_W-1:0]    sw_rdata_o,
    output logic                fpe_req_o,
    output logic [PC_W-1:0]     fpe_pc_o
);
    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             req;
        logic [PC_W-1:0]  pc;
    } state_t;

    state_t state_d, state_q;

    logic [CSR_W-1:0] new_flags;
    logic [CSR_W-1:0] merged;
    logic             trig_hit;
    logic             accept;

    fpx_cause_fold u_fold (
        .cause_i (op_cause_i),
        .flags_o (new_flags)
    );

    assign merged = state_q.csr | (new_flags & ~KEEP_MASK);

    fpx_event_check #(
        .W    (CSR_W),
        .MASK (TRIG_MASK)
    ) u_trig (
        .value_i (merged),
        .hit_o   (trig_hit)
    );

    assign accept = op_valid_i & state_q.csr[B_EN] & ~sw_we_i;

    always_comb begin
        state_d     = state_q;
        state_d.req = 1'b0;
        if (sw_we_i) begin
            state_d.csr = sw_wdata_i;
        end else if (accept) begin
            state_d.csr = merged;
            if (trig_hit) begin
                state_d.req = 1'b1;
                state_d.pc  = op_pc_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sw_rdata_o = state_q.csr;
    assign fpe_req_o  = state_q.req;
    assign fpe_pc_o   = state_q.pc;
endmodule

// File: rtl/fpx_flag_accum_chk.sv
module fpx_flag_accum_chk
    import fpx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                op_valid_i,
    input logic [CAUSE_W-1:0]  op_cause_i,
    input logic [PC_W-1:0]     op_pc_i,
    input logic                sw_we_i,
    input logic [CSR_W-1:0]    sw_wdata_i,
    input logic [CSR_W-1:0]    sw_rdata_o,
    input logic                fpe_req_o,
    input logic [PC_W-1:0]     fpe_pc_o
);
    // R2: disabled report leaves the register alone and raises nothing
    a_r2_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !sw_rdata_o[B_EN] && !sw_we_i) |=> ($stable(sw_rdata_o) && !fpe_req_o));

    // R7: without a write, no register bit ever drops
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sw_we_i |=> (($past(sw_rdata_o) & ~sw_rdata_o) == '0));

    // R8: a request only appears with a triggering flag set
    a_r8_req_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fpe_req_o |-> ((sw_rdata_o & TRIG_MASK) != '0));

    // R8: no accepted report means no request next cycle
    a_r8_req_needs_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(op_valid_i && sw_rdata_o[B_EN] && !sw_we_i) |=> !fpe_req_o);

    // R8: tagged PC follows the accepted report
    a_r8_pc_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && sw_rdata_o[B_EN] && !sw_we_i) |=> (!fpe_req_o || fpe_pc_o == $past(op_pc_i)));

    // R9: a write lands whole and suppresses any request
    a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_we_i |=> (sw_rdata_o == $past(sw_wdata_i) && !fpe_req_o));

    // R10: control bits and zero flag untouched without a write
    a_r10_ctrl_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sw_we_i |=> ((sw_rdata_o & KEEP_MASK) == ($past(sw_rdata_o) & KEEP_MASK)));
endmodule

bind fpx_flag_accum fpx_flag_accum_chk #(.PC_W(PC_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_cause_i (op_cause_i),
    .op_pc_i    (op_pc_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .sw_rdata_o (sw_rdata_o),
    .fpe_req_o  (fpe_req_o),
    .fpe_pc_o   (fpe_pc_o)
);

// File: tb/fpx_flag_accum_tb_top.sv
`timescale 1ns/1ps
module fpx_flag_accum_tb_top;
    localparam int PC_W = 32;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            op_valid_i = 1'b0;
    logic [12:0]     op_cause_i = '0;
    logic [PC_W-1:0] op_pc_i = '0;
    logic            sw_we_i = 1'b0;
    logic [11:0]     sw_wdata_i = '0;
    logic [11:0]     sw_rdata_o;
    logic            fpe_req_o;
    logic [PC_W-1:0] fpe_pc_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [11:0]     m_csr = '0;
    logic            m_req = 1'b0;
    logic [PC_W-1:0] m_pc  = '0;

    always #4 clk_i = ~clk_i;

    fpx_flag_accum #(.PC_W(PC_W)) dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_valid_i (op_valid_i),
        .op_cause_i (op_cause_i),
        .op_pc_i    (op_pc_i),
        .sw_we_i    (sw_we_i),
        .sw_wdata_i (sw_wdata_i),
        .sw_rdata_o (sw_rdata_o),
        .fpe_req_o  (fpe_req_o),
        .fpe_pc_o   (fpe_pc_o)
    );

    function automatic logic [11:0] fold_ref(logic [12:0] c);
        logic [11:0] f = '0;
        f[9]  = |c[8:0];
        f[5]  = c[0];
        f[6]  = c[1];
        f[10] = c[2] | c[3];
        f[3]  = c[9];
        f[4]  = c[10];
        f[11] = c[11];
        f[8]  = c[12];
        return f;
    endfunction

    function automatic string tag_of(int i);
        if (i <= 1) return "R4";
        if (i <= 3) return "R6";
        if (i <= 8) return "R3";
        return "R5";
    endfunction

    task automatic cmp(string tag, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "csr", PC_W'(sw_rdata_o), PC_W'(m_csr));
        cmp(tag, "req", PC_W'(fpe_req_o), PC_W'(m_req));
        cmp(tag, "pc",  fpe_pc_o, m_pc);
    endtask

    // called at a negedge; drives, waits one edge, updates model, checks at next negedge
    task automatic step(bit v, logic [12:0] c, logic [PC_W-1:0] pc, bit we, logic [11:0] wd, string tag);
        logic [11:0] nxt;
        op_valid_i = v; op_cause_i = c; op_pc_i = pc; sw_we_i = we; sw_wdata_i = wd;
        @(posedge clk_i);
        m_req = 1'b0;
        if (we) begin
            m_csr = wd;
        end else if (v && m_csr[0]) begin
            nxt   = m_csr | fold_ref(c);
            m_csr = nxt;
            if ((nxt & 12'hF78) != 0) begin
                m_req = 1'b1;
                m_pc  = pc;
            end
        end
        @(negedge clk_i);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        check_all("R1");
        rst_ni = 1'b1;
        @(negedge clk_i);
        check_all("R1");

        // R2: enable clear, every cause present
        step(1, 13'h1FFF, 32'h100, 0, '0, "R2");
        // R9: write enable plus rounding mode
        step(0, '0, '0, 1, 12'h005, "R9");

        // each cause alone from a clean register
        for (int i = 0; i < 13; i++) begin
            step(0, '0, '0, 1, 12'h005, "R9");
            step(1, 13'(1) << i, 32'h2000 + 32'(i * 4), 0, '0, tag_of(i));
        end

        // R7 and R8: sticky accumulation, then an empty report still triggers
        step(0, '0, '0, 1, 12'h001, "R9");
        step(1, 13'h0200, 32'h3000, 0, '0, "R7");
        step(1, 13'h0400, 32'h3004, 0, '0, "R7");
        step(1, 13'h0000, 32'h3008, 0, '0, "R8");
        step(0, '0, '0, 0, '0, "R8");

        // R8: zero flag alone does not trigger
        step(0, '0, '0, 1, 12'h081, "R9");
        step(1, 13'h0000, 32'h4000, 0, '0, "R8");

        // R9: write collides with a report
        step(1, 13'h1FFF, 32'h5000, 1, 12'h003, "R9");
        // R10: report keeps control bits and never sets zero flag
        step(1, 13'h1FFF, 32'h5004, 0, '0, "R10");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [12:0] c = '0;
            bit          v = ($urandom % 4) != 0;
            bit          we = ($urandom % 16) == 0;
            logic [11:0] wd = 12'($urandom);
            for (int b = 0; b < 13; b++) c[b] = ($urandom % 8) == 0;
            if (($urandom % 5) != 0) wd[0] = 1'b1;
            if (($urandom % 3) == 0) wd[11:3] = '0;
            step(v, c, $urandom, we, wd, "R7_R8");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule